// File: doc/BRIEF.md
# Switchable-Byte-Order Aligned Load/Store Unit

This unit sits between the load/store requests of a processor core and a data memory that is addressed by words. Each request carries a byte address, an access width (byte, halfword or word), a load or store flag, a signed or unsigned flag for loads, store data, and a byte-order select. The byte-order select can change at run time. The unit takes one request at a time. It captures the request, checks that the address suits the access width, and then either issues one memory cycle or, if the address is illegal, reports a fault without touching memory.

For stores, the unit moves the store value into the memory byte lanes that the address names and raises only the matching byte enables. For loads, it takes the addressed bytes out of the returned word, puts them in the order set by the byte-order select, and widens them to the full data width with sign fill or zero fill. A request is accepted in `ST_IDLE`. The unit then moves to `ST_ISSUE`, where it checks the address and drives the memory. From there it goes to one of three one-cycle response states, `ST_LOAD_RSP`, `ST_STORE_RSP` or `ST_FAULT_RSP`, and after that it always returns to `ST_IDLE`. In `ST_ISSUE`, a misaligned request takes the transition to `ST_FAULT_RSP`, an aligned store goes to `ST_STORE_RSP`, and an aligned load goes to `ST_LOAD_RSP`.

Top module: `lsu_endian_align`

## Requirements
- R1: The width code `req_size` is 0 for byte, 1 for halfword, 2 for word, and 3 is reserved. Byte accesses are legal at every address. Halfword accesses are legal only when address bit 0 is 0. Word accesses are legal only when address bits 1:0 are 00. Code 3 is always illegal.
- R2: An illegal request raises `rsp_fault` together with `rsp_valid` for exactly one cycle. It raises no `mem_en` and leaves every memory byte as it was.
- R3: With `req_big_endian` = 0, the byte at address offset o (o = address bits 1:0) is lane o, where lane i is data bits 8i+7:8i. Value byte k (k = 0 is least significant) is at address A+k.
- R4: With `req_big_endian` = 1, the byte at address offset o is lane 3-o. Value byte k of an n-byte access is at address A+n-1-k, so the most significant byte is at the lowest address.
- R5: An aligned store raises `mem_be` only on the lanes its bytes map to, and it carries each value byte on its lane of `mem_wdata`. No other memory byte changes. A load drives `mem_be` to 0.
- R6: A byte or halfword load fills the bits above the access with copies of its top bit when `req_signed` = 1, and with zeros when `req_signed` = 0.
- R7: The byte order, address, width, data and flags are taken at acceptance. Changing the request inputs after acceptance does not alter the access in flight.
- R8: A request is accepted on a rising edge with `req_valid` and `req_ready` both high. `req_ready` is high only in `ST_IDLE`. The memory cycle (`mem_en`, `mem_we`, `mem_addr` = address bits 15:2) is driven in the next cycle. `rsp_valid` is high in the cycle after that, and `req_ready` returns in the cycle after the response.
- R9: While reset is low and after it is released, the unit is in `ST_IDLE` with `req_ready` = 1, `rsp_valid` = 0 and `mem_en` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit idle and able to accept a request |
| req_addr | input | ADDR_W | Byte address |
| req_size | input | 2 | Access width code (0 byte, 1 half, 2 word) |
| req_store | input | 1 | 1 = store, 0 = load |
| req_signed | input | 1 | Load fill: 1 = sign, 0 = zero |
| req_big_endian | input | 1 | Byte order: 1 = most significant byte first |
| req_wdata | input | DATA_W | Store value, right-aligned |
| rsp_valid | output | 1 | Response cycle |
| rsp_fault | output | 1 | Request was misaligned and not performed |
| rsp_rdata | output | DATA_W | Widened load value |
| mem_en | output | 1 | Memory cycle enable |
| mem_we | output | 1 | Memory write |
| mem_addr | output | ADDR_W-2 | Word address |
| mem_be | output | DATA_W/8 | Byte-lane write enables |
| mem_wdata | output | DATA_W | Lane-steered write data |
| mem_rdata | input | DATA_W | Read word, valid one cycle after a read |

## Verification
The bench goes after the lane mirror in big-endian mode. A design that forgets to mirror a halfword would return the other half of the word, and one that mirrors words as well would byte-swap every full-word access. Halfword and word requests at every odd or non-multiple-of-four offset, plus the reserved width code, check that a fault suppresses the memory write. A design that faults but still writes would corrupt a neighbouring byte, and the full memory image compare made after each request catches that. Loads with the top bit set in both fill modes expose a swapped sign and zero fill. After every acceptance the bench scrambles all the request inputs, including the byte-order select, so a unit that reads them live instead of from the captured copy steers to the wrong lanes.

// File: rtl/lsu_pkg.sv
package lsu_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } acc_size_e;

    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_ISSUE     = 3'd1,
        ST_LOAD_RSP  = 3'd2,
        ST_STORE_RSP = 3'd3,
        ST_FAULT_RSP = 3'd4
    } lsu_state_e;

    typedef struct packed {
        acc_size_e size;
        logic      store;
        logic      sext;
        logic      big;
    } req_attr_t;

endpackage

// File: rtl/lsu_align_chk.sv
module lsu_align_chk
    import lsu_pkg::*;
#(
    parameter int OFF_W = 2
)(
    input  acc_size_e        size,
    input  logic [OFF_W-1:0] off,
    output logic             misaligned
);

    // Legality depends only on the low address bits and the width.
    always_comb begin
        unique case (size)
            SZ_BYTE: misaligned = 1'b0;
            SZ_HALF: misaligned = off[0];
            SZ_WORD: misaligned = |off[1:0];
            SZ_RSVD: misaligned = 1'b1;
        endcase
    end

endmodule

// File: rtl/lsu_lane_steer.sv
module lsu_lane_steer
    import lsu_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int LANES = DATA_W / 8,
    localparam int OFF_W = $clog2(LANES)
)(
    input  acc_size_e          size,
    input  logic [OFF_W-1:0]   off,
    input  logic               big,
    input  logic [DATA_W-1:0]  wdata,
    output logic [OFF_W-1:0]   lane_low,
    output logic [LANES-1:0]   be,
    output logic [DATA_W-1:0]  wdata_lanes
);

    logic [OFF_W:0]     nbytes;
    logic [OFF_W:0]     mirrored;
    logic [LANES-1:0]   size_mask;

    always_comb begin
        unique case (size)
            SZ_BYTE: nbytes = (OFF_W+1)'(1);
            SZ_HALF: nbytes = (OFF_W+1)'(2);
            SZ_WORD: nbytes = (OFF_W+1)'(4);
            SZ_RSVD: nbytes = '0;
        endcase
    end

    // Big-endian mirrors the access inside the word: the lowest
    // lane used sits at LANES - nbytes - off instead of at off.
    assign mirrored = (OFF_W+1)'(LANES) - nbytes - {1'b0, off};
    assign lane_low = big ? mirrored[OFF_W-1:0] : off;

    for (genvar l = 0; l < LANES; l++) begin : g_mask
        assign size_mask[l] = ((OFF_W+1)'(l) < nbytes);
    end

    assign be          = size_mask << lane_low;
    assign wdata_lanes = wdata << {lane_low, 3'b000};

endmodule

// File: rtl/lsu_load_extract.sv
module lsu_load_extract
    import lsu_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int LANES = DATA_W / 8,
    localparam int OFF_W = $clog2(LANES)
)(
    input  logic [DATA_W-1:0] rdata,
    input  logic [OFF_W-1:0]  lane_low,
    input  acc_size_e         size,
    input  logic              sext,
    output logic [DATA_W-1:0] value
);

    logic [DATA_W-1:0] shifted;
    int unsigned       nbits;
    logic              top_bit;

    assign shifted = rdata >> {lane_low, 3'b000};

    always_comb begin
        unique case (size)
            SZ_BYTE: begin nbits = 8;  top_bit = shifted[7];  end
            SZ_HALF: begin nbits = 16; top_bit = shifted[15]; end
            SZ_WORD: begin nbits = 32; top_bit = shifted[31]; end
            SZ_RSVD: begin nbits = 32; top_bit = 1'b0;        end
        endcase
    end

    always_comb begin
        for (int i = 0; i < DATA_W; i++) begin
            value[i] = (i < int'(nbits)) ? shifted[i] : (sext & top_bit);
        end
    end

endmodule

// File: rtl/lsu_endian_align.sv
module lsu_endian_align
    import lsu_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    localparam int LANES   = DATA_W / 8,
    localparam int OFF_W   = $clog2(LANES),
    localparam int WADDR_W = ADDR_W - OFF_W
)(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [1:0]         req_size,
    input  logic               req_store,
    input  logic               req_signed,
    input  logic               req_big_endian,
    input  logic [DATA_W-1:0]  req_wdata,
    output logic               rsp_valid,
    output logic               rsp_fault,
    output logic [DATA_W-1:0]  rsp_rdata,
    output logic               mem_en,
    output logic               mem_we,
    output logic [WADDR_W-1:0] mem_addr,
    output logic [LANES-1:0]   mem_be,
    output logic [DATA_W-1:0]  mem_wdata,
    input  logic [DATA_W-1:0]  mem_rdata
);

    lsu_state_e        state_q, state_d;
    logic [ADDR_W-1:0] q_addr;
    req_attr_t         q_attr;
    logic [DATA_W-1:0] q_wdata;

    logic              accept;
    logic              misaligned;
    logic [OFF_W-1:0]  q_off;
    logic [1:0]        q_size;
    logic [OFF_W-1:0]  lane_low;
    logic [LANES-1:0]  lane_be;
    logic [DATA_W-1:0] steered_wdata;
    logic [DATA_W-1:0] load_value;

    assign accept = req_valid && (state_q == ST_IDLE);
    assign q_off  = q_addr[OFF_W-1:0];
    assign q_size = q_attr.size;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Request capture: everything, byte order included, is frozen here
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_addr  <= '0;
            q_attr  <= '{size: SZ_BYTE, store: 1'b0, sext: 1'b0, big: 1'b0};
            q_wdata <= '0;
        end else if (accept) begin
            q_addr  <= req_addr;
            q_attr  <= '{size:  acc_size_e'(req_size),
                         store: req_store,
                         sext:  req_signed,
                         big:   req_big_endian};
            q_wdata <= req_wdata;
        end
    end

    lsu_align_chk #(.OFF_W(OFF_W)) u_align (
        .size       (q_attr.size),
        .off        (q_off),
        .misaligned (misaligned)
    );

    lsu_lane_steer #(.DATA_W(DATA_W)) u_steer (
        .size        (q_attr.size),
        .off         (q_off),
        .big         (q_attr.big),
        .wdata       (q_wdata),
        .lane_low    (lane_low),
        .be          (lane_be),
        .wdata_lanes (steered_wdata)
    );

    lsu_load_extract #(.DATA_W(DATA_W)) u_extract (
        .rdata    (mem_rdata),
        .lane_low (lane_low),
        .size     (q_attr.size),
        .sext     (q_attr.sext),
        .value    (load_value)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) state_d = ST_ISSUE;
            end
            ST_ISSUE: begin
                if (misaligned)        state_d = ST_FAULT_RSP;
                else if (q_attr.store) state_d = ST_STORE_RSP;
                else                   state_d = ST_LOAD_RSP;
            end
            ST_LOAD_RSP:  state_d = ST_IDLE;
            ST_STORE_RSP: state_d = ST_IDLE;
            ST_FAULT_RSP: state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    // Outputs
    assign mem_addr  = q_addr[ADDR_W-1:OFF_W];
    assign mem_wdata = steered_wdata;

    always_comb begin
        req_ready = 1'b0;
        rsp_valid = 1'b0;
        rsp_fault = 1'b0;
        rsp_rdata = '0;
        mem_en    = 1'b0;
        mem_we    = 1'b0;
        mem_be    = '0;
        unique case (state_q)
            ST_IDLE: req_ready = 1'b1;
            ST_ISSUE: begin
                mem_en = !misaligned;
                mem_we = !misaligned && q_attr.store;
                mem_be = (!misaligned && q_attr.store) ? lane_be : '0;
            end
            ST_LOAD_RSP: begin
                rsp_valid = 1'b1;
                rsp_rdata = load_value;
            end
            ST_STORE_RSP: rsp_valid = 1'b1;
            ST_FAULT_RSP: begin
                rsp_valid = 1'b1;
                rsp_fault = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/lsu_endian_align_chk.sv
module lsu_endian_align_chk #(
    parameter int LANES = 4,
    parameter int OFF_W = 2
)(
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic             rsp_valid,
    input logic             rsp_fault,
    input logic             mem_en,
    input logic             mem_we,
    input logic [LANES-1:0] mem_be,
    input logic [1:0]       q_size,
    input logic [OFF_W-1:0] q_off
);

    assert_aligned_issue_R1: assert property (@(posedge clk) disable iff (!rst_n)
        mem_en |-> ((q_size == 2'd0) ||
                    (q_size == 2'd1 && !q_off[0]) ||
                    (q_size == 2'd2 && q_off[1:0] == 2'b00)));

    assert_fault_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault |=> !rsp_fault);

    assert_fault_no_access_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault |-> (rsp_valid && $past(!mem_en)));

    assert_store_lanes_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && mem_we) |->
            ($countones(mem_be) == ((q_size == 2'd0) ? 1 : (q_size == 2'd1) ? 2 : 4)));

    assert_load_no_be_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && !mem_we) |-> (mem_be == '0));

    assert_busy_after_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (!req_ready && !rsp_valid));

    assert_rsp_after_access_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_en |=> (rsp_valid && !rsp_fault));

    assert_ready_after_rsp_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> req_ready);

endmodule

bind lsu_endian_align lsu_endian_align_chk #(.LANES(LANES), .OFF_W(OFF_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .rsp_fault (rsp_fault),
    .mem_en    (mem_en),
    .mem_we    (mem_we),
    .mem_be    (mem_be),
    .q_size    (q_size),
    .q_off     (q_off)
);

// File: tb/tb_lsu_endian_align.sv
`timescale 1ns/1ps
module tb_lsu_endian_align;

    localparam int ADDR_W = 16;
    localparam int DATA_W = 32;
    localparam int MEMW   = 16;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic              rst_n;
    logic              req_valid, req_ready;
    logic [ADDR_W-1:0] req_addr;
    logic [1:0]        req_size;
    logic              req_store, req_signed, req_big_endian;
    logic [DATA_W-1:0] req_wdata;
    logic              rsp_valid, rsp_fault;
    logic [DATA_W-1:0] rsp_rdata;
    logic              mem_en, mem_we;
    logic [ADDR_W-3:0] mem_addr;
    logic [3:0]        mem_be;
    logic [DATA_W-1:0] mem_wdata;
    logic [DATA_W-1:0] mem_rdata;

    lsu_endian_align #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_size(req_size), .req_store(req_store),
        .req_signed(req_signed), .req_big_endian(req_big_endian),
        .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_rdata(rsp_rdata),
        .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    int n_checks = 0;
    int n_err    = 0;

    function automatic logic [7:0] pat(int w, int l);
        return 8'((w * 37 + l * 71 + 5) & 255);
    endfunction

    // Environment memory: synchronous read, per-lane write
    logic [31:0] tb_mem [MEMW];
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int w = 0; w < MEMW; w++)
                for (int l = 0; l < 4; l++) tb_mem[w][8*l +: 8] <= pat(w, l);
        end else if (mem_en) begin
            if (mem_we) begin
                for (int l = 0; l < 4; l++)
                    if (mem_be[l]) tb_mem[mem_addr[3:0]][8*l +: 8] <= mem_wdata[8*l +: 8];
            end else begin
                mem_rdata <= tb_mem[mem_addr[3:0]];
            end
        end
    end

    // Reference model: expected byte in each word/lane
    logic [7:0] ref_b [MEMW][4];

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    // Starts and ends at a falling edge with the unit idle.
    task automatic do_req(input int addr, input int size, input bit st,
                          input bit sgn, input bit big, input logic [31:0] wd);
        bit          fault;
        int          nb, w;
        logic [3:0]  ebe;
        logic [7:0]  elane [4];
        logic [31:0] eval, lowmask;
        string       ordtag;
        fault = (size == 3) || (size == 1 && (addr % 2) != 0) ||
                (size == 2 && (addr % 4) != 0);
        nb = (size == 0) ? 1 : (size == 1) ? 2 : 4;
        w  = (addr / 4) % MEMW;
        ordtag = big ? "R4" : "R3";
        ebe = '0; eval = '0;
        for (int l = 0; l < 4; l++) elane[l] = '0;
        if (!fault) begin
            for (int k = 0; k < nb; k++) begin
                int a, lane, vb;
                a    = addr + k;
                lane = big ? 3 - (a % 4) : (a % 4);
                vb   = big ? nb - 1 - k : k;
                if (st) begin
                    ebe[lane]   = 1'b1;
                    elane[lane] = wd[8*vb +: 8];
                end else begin
                    eval[8*vb +: 8] = ref_b[w][lane];
                end
            end
        end
        lowmask = (nb == 4) ? 32'hFFFF_FFFF : ((32'h1 << (8 * nb)) - 1);
        if (sgn && nb < 4 && eval[8*nb-1]) eval = eval | ~lowmask;

        req_addr = ADDR_W'(addr); req_size = 2'(size); req_store = st;
        req_signed = sgn; req_big_endian = big; req_wdata = wd; req_valid = 1'b1;
        chk(req_ready == 1'b1, "R8", "ready before accept", 32'(req_ready), 32'd1);
        @(posedge clk);
        @(negedge clk);
        // R7: scramble every request input once the request is captured
        req_valid = 1'b0; req_big_endian = !big; req_signed = !sgn;
        req_addr = ADDR_W'($urandom); req_size = 2'($urandom);
        req_store = !st; req_wdata = $urandom;
        chk(req_ready == 1'b0, "R8", "busy in issue", 32'(req_ready), 32'd0);
        chk(mem_en == !fault, fault ? "R2" : "R1", "mem_en", 32'(mem_en), 32'(!fault));
        if (!fault) begin
            chk(mem_we == st, "R8", "mem_we", 32'(mem_we), 32'(st));
            chk(mem_addr == 14'(w), "R8", "mem_addr", 32'(mem_addr), 32'(w));
            if (st) begin
                chk(mem_be == ebe, ordtag, "byte enables R7", 32'(mem_be), 32'(ebe));
                for (int l = 0; l < 4; l++)
                    if (ebe[l]) chk(mem_wdata[8*l +: 8] == elane[l], "R5",
                                    "store lane data", 32'(mem_wdata[8*l +: 8]), 32'(elane[l]));
            end else begin
                chk(mem_be == 4'h0, "R5", "load byte enables", 32'(mem_be), 32'd0);
            end
        end
        @(negedge clk);
        chk(rsp_valid == 1'b1, "R8", "response valid", 32'(rsp_valid), 32'd1);
        chk(rsp_fault == fault, fault ? "R2" : "R1", "fault flag", 32'(rsp_fault), 32'(fault));
        chk(mem_en == 1'b0, "R8", "no access in response", 32'(mem_en), 32'd0);
        if (!st && !fault) begin
            chk((rsp_rdata & lowmask) == (eval & lowmask), ordtag, "load bytes R7",
                rsp_rdata, eval);
            if (nb < 4) chk(rsp_rdata == eval, "R6", "load fill", rsp_rdata, eval);
        end
        if (st && !fault)
            for (int l = 0; l < 4; l++) if (ebe[l]) ref_b[w][l] = elane[l];
        begin
            bit same;
            same = 1'b1;
            for (int ww = 0; ww < MEMW; ww++)
                for (int l = 0; l < 4; l++)
                    if (tb_mem[ww][8*l +: 8] !== ref_b[ww][l]) same = 1'b0;
            chk(same, fault ? "R2" : "R5", "memory image", 32'(same), 32'd1);
        end
        @(negedge clk);
        chk(req_ready && !rsp_valid, "R8", "idle after response",
            32'({req_ready, rsp_valid}), 32'b10);
    endtask

    initial begin
        for (int w = 0; w < MEMW; w++)
            for (int l = 0; l < 4; l++) ref_b[w][l] = pat(w, l);
        rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_size = '0;
        req_store = 1'b0; req_signed = 1'b0; req_big_endian = 1'b0; req_wdata = '0;
        repeat (3) @(negedge clk);
        chk(req_ready == 1'b1, "R9", "ready in reset", 32'(req_ready), 32'd1);
        chk(rsp_valid == 1'b0, "R9", "no response in reset", 32'(rsp_valid), 32'd0);
        chk(mem_en == 1'b0, "R9", "no access in reset", 32'(mem_en), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && !rsp_valid && !mem_en, "R9", "idle after reset",
            32'({req_ready, rsp_valid, mem_en}), 32'b100);

        // R3 / R4: one word seen in both orders
        do_req(16, 2, 1, 0, 0, 32'h1122_3344);
        do_req(16, 2, 0, 0, 0, 0);
        do_req(16, 2, 0, 0, 1, 0);
        do_req(16, 0, 0, 0, 0, 0);
        do_req(16, 0, 0, 0, 1, 0);
        do_req(18, 1, 0, 0, 0, 0);
        do_req(18, 1, 0, 0, 1, 0);
        // R4 / R5: big-endian byte stores at every offset, read back little-endian
        for (int o = 0; o < 4; o++) do_req(20 + o, 0, 1, 0, 1, 32'hA0 + 32'(o));
        do_req(20, 2, 0, 0, 0, 0);
        // R6: fill with the top bit set
        do_req(24, 1, 1, 0, 0, 32'h0000_8001);
        do_req(26, 1, 1, 0, 1, 32'h0000_80FE);
        do_req(24, 1, 0, 1, 0, 0);
        do_req(24, 1, 0, 0, 0, 0);
        do_req(26, 1, 0, 1, 1, 0);
        do_req(25, 0, 0, 1, 0, 0);
        do_req(25, 0, 0, 0, 1, 0);
        // R1 / R2: illegal addresses and the reserved width
        do_req(33, 1, 1, 0, 0, 32'hDEAD_BEEF);
        do_req(33, 2, 1, 0, 1, 32'hDEAD_BEEF);
        do_req(34, 2, 1, 0, 0, 32'hDEAD_BEEF);
        do_req(35, 2, 0, 1, 0, 0);
        do_req(32, 3, 1, 0, 0, 32'hDEAD_BEEF);
        do_req(32, 2, 0, 0, 0, 0);
        // Mixed traffic
        for (int i = 0; i < 400; i++)
            do_req(int'($urandom_range(0, 63)), int'($urandom_range(0, 3)),
                   bit'($urandom), bit'($urandom), bit'($urandom), $urandom);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_err++;
        $display("FAIL R8 watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

endmodule